// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and decides its fault-confinement state. The protocol engine sends it single-cycle event pulses: a transmit error, a receive error, a minor receive error that counts by one, a successful transmit, a successful receive, and a pulse each time it sees a run of eleven recessive bits. The block does not work out which protocol rule produced an event. It only applies the counting rules and the thresholds.

The block outputs both counter values and the current state, which is error active, error passive or bus off. It also raises a one-cycle interrupt pulse whenever the state changes. Counter width, error step, the passive threshold, the receive reload value and the number of recessive runs needed for recovery are all parameters.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read zero, `state_o` is 2'b00 (error active) and no interrupt output is high.
- R2: A `tx_err_i` pulse adds 8 to the transmit counter. A `rx_err_i` pulse adds 8 to the receive counter. A `rx_err_one_i` pulse adds 1 to the receive counter. When `rx_err_i` and `rx_err_one_i` arrive in the same cycle, only the 8 is added.
- R3: A `tx_ok_i` pulse subtracts 1 from the transmit counter and a `rx_ok_i` pulse subtracts 1 from the receive counter. A counter that is already at zero stays at zero.
- R4: When an increment and a decrement for the same counter arrive in the same cycle, the increment is applied and the decrement is dropped.
- R5: A receive increment that would pass 255 leaves the receive counter at 255.
- R6: From error active, the state becomes 2'b01 (error passive) on the clock edge where either counter's new value exceeds 127. `irq_passive_o` is high for the one cycle after that edge.
- R7: From error passive, the state returns to 2'b00 on the edge where both new counter values are 127 or less. On that edge the receive counter is loaded with 119, and `irq_active_o` pulses for one cycle.
- R8: A `tx_err_i` pulse that would take the transmit counter past 255 moves the state to 2'b10 (bus off). The transmit counter keeps its previous value, and `irq_busoff_o` pulses for one cycle.
- R9: While the state is bus off, all error and success pulses leave both counters unchanged.
- R10: Bus off ends on the edge of the 128th `recess_run_i` pulse counted since bus off was entered. On that edge both counters clear, the state becomes 2'b00 and `irq_active_o` pulses. `recess_run_i` has no effect in the other two states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err_i | input | 1 | Transmit error event |
| tx_ok_i | input | 1 | Successful transmit event |
| rx_err_i | input | 1 | Receive error event (step 8) |
| rx_err_one_i | input | 1 | Receive error event (step 1) |
| rx_ok_i | input | 1 | Successful receive event |
| recess_run_i | input | 1 | Eleven consecutive recessive bits seen |
| tx_cnt_o | output | 8 | Transmit error counter |
| rx_cnt_o | output | 8 | Receive error counter |
| state_o | output | 2 | 00 active, 01 passive, 10 bus off |
| irq_passive_o | output | 1 | Pulse on entry to error passive |
| irq_busoff_o | output | 1 | Pulse on entry to bus off |
| irq_active_o | output | 1 | Pulse on return to error active |

## Verification
All counters and the state register drive the ports directly. A wrong counter step, a missed floor or ceiling, or a bad state decision therefore shows on the outputs one cycle after the event that caused it. The bench compares against its model on every cycle, so such a fault is caught at that cycle. A recovery counter that runs early or late stays hidden while the node is bus off. It only shows when the exit comes one or more pulses away from the 128th recessive run, so the bench drives that exit both with a directed count and under random traffic.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'b00,
      FC_PASSIVE = 2'b01,
      FC_BUSOFF  = 2'b10
   } fc_state_e;

endpackage

// File: rtl/can_fc_errcnt.sv
// Saturating up/down error counter slice. SATURATE selects the overflow
// behaviour: clamp to all ones, or keep the present value.
module can_fc_errcnt #(
   parameter int W        = 8,
   parameter int BIG_STEP = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_big_i,
   input  logic         inc_one_i,
   input  logic         dec_i,
   input  logic         freeze_i,
   input  logic         clear_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] step_o,
   output logic         ovf_o
);

   localparam logic [W:0] MAX_V = {1'b0, {W{1'b1}}};
   localparam logic [W:0] BIG_V = (W+1)'(BIG_STEP);
   localparam logic [W:0] ONE_V = (W+1)'(1);

   if (W < 2) begin : g_bad_width
      $error("can_fc_errcnt: W must be at least 2");
   end
   if (BIG_STEP < 1 || BIG_STEP >= (1 << W)) begin : g_bad_step
      $error("can_fc_errcnt: BIG_STEP out of range");
   end

   logic [W-1:0] q;
   logic [W:0]   sum;
   logic [W-1:0] ovf_val;
   logic         incr;

   assign incr = inc_big_i | inc_one_i;
   assign sum  = {1'b0, q} + (inc_big_i ? BIG_V : ONE_V);

   if (SATURATE) begin : g_clamp
      assign ovf_val = {W{1'b1}};
   end else begin : g_hold
      assign ovf_val = q;
   end

   always_comb begin
      ovf_o  = 1'b0;
      step_o = q;
      if (incr) begin
         if (sum > MAX_V) begin
            ovf_o  = 1'b1;
            step_o = ovf_val;
         end else begin
            step_o = sum[W-1:0];
         end
      end else if (dec_i && q != '0) begin
         step_o = q - W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         q <= '0;
      end else if (load_i) begin
         q <= load_val_i;
      end else if (!freeze_i) begin
         q <= step_o;
      end
   end

   assign q_o = q;

endmodule

// File: rtl/can_fc_recover.sv
// Counts recessive-run pulses while enabled; done fires on the last one.
module can_fc_recover #(
   parameter int COUNT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic pulse_i,
   output logic done_o
);

   localparam int CW = (COUNT > 2) ? $clog2(COUNT) : 1;
   localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

   if (COUNT < 2) begin : g_bad_count
      $error("can_fc_recover: COUNT must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign done_o = en_i && pulse_i && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i || done_o) begin
         cnt <= '0;
      end else if (pulse_i) begin
         cnt <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/can_fc_ctrl.sv
// Fault-confinement state register and transition pulses.
module can_fc_ctrl
   import can_fc_pkg::*;
#(
   parameter int W     = 8,
   parameter int LIMIT = 127
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] tx_step_i,
   input  logic [W-1:0] rx_step_i,
   input  logic         tx_ovf_i,
   input  logic         recov_done_i,
   output fc_state_e    state_o,
   output logic         rx_load_o,
   output logic         clear_o,
   output logic         irq_passive_o,
   output logic         irq_busoff_o,
   output logic         irq_active_o
);

   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   fc_state_e state_q, state_d;
   logic      tx_hi, rx_hi;

   assign tx_hi   = tx_step_i > LIM_V;
   assign rx_hi   = rx_step_i > LIM_V;
   assign clear_o = recov_done_i;

   always_comb begin
      state_d   = state_q;
      rx_load_o = 1'b0;
      unique case (state_q)
         FC_ACTIVE: begin
            if (tx_ovf_i)            state_d = FC_BUSOFF;
            else if (tx_hi || rx_hi) state_d = FC_PASSIVE;
         end
         FC_PASSIVE: begin
            if (tx_ovf_i) begin
               state_d = FC_BUSOFF;
            end else if (!tx_hi && !rx_hi) begin
               state_d   = FC_ACTIVE;
               rx_load_o = 1'b1;
            end
         end
         FC_BUSOFF: begin
            if (recov_done_i) state_d = FC_ACTIVE;
         end
         default: state_d = FC_ACTIVE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= FC_ACTIVE;
         irq_passive_o <= 1'b0;
         irq_busoff_o  <= 1'b0;
         irq_active_o  <= 1'b0;
      end else begin
         state_q       <= state_d;
         irq_passive_o <= (state_d != state_q) && (state_d == FC_PASSIVE);
         irq_busoff_o  <= (state_d != state_q) && (state_d == FC_BUSOFF);
         irq_active_o  <= (state_d != state_q) && (state_d == FC_ACTIVE);
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int ERR_STEP      = 8,
   parameter int PASSIVE_LIMIT = 127,
   parameter int RX_RELOAD     = 119,
   parameter int RECOVER_COUNT = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_err_i,
   input  logic             tx_ok_i,
   input  logic             rx_err_i,
   input  logic             rx_err_one_i,
   input  logic             rx_ok_i,
   input  logic             recess_run_i,
   output logic [CNT_W-1:0] tx_cnt_o,
   output logic [CNT_W-1:0] rx_cnt_o,
   output logic [1:0]       state_o,
   output logic             irq_passive_o,
   output logic             irq_busoff_o,
   output logic             irq_active_o
);

   localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RX_RELOAD);

   if (PASSIVE_LIMIT < 1 || PASSIVE_LIMIT >= (1 << CNT_W) - 1) begin : g_bad_limit
      $error("can_fault_conf: PASSIVE_LIMIT out of range");
   end
   if (RX_RELOAD > PASSIVE_LIMIT || RX_RELOAD < 0) begin : g_bad_reload
      $error("can_fault_conf: RX_RELOAD must not exceed PASSIVE_LIMIT");
   end

   fc_state_e        state;
   logic             busoff, rx_load, clr, recov_done, tx_ovf, rx_ovf;
   logic [CNT_W-1:0] tx_step, rx_step;

   assign busoff = (state == FC_BUSOFF);

   can_fc_errcnt #(.W(CNT_W), .BIG_STEP(ERR_STEP), .SATURATE(1'b0)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_big_i  (tx_err_i),
      .inc_one_i  (1'b0),
      .dec_i      (tx_ok_i),
      .freeze_i   (busoff),
      .clear_i    (clr),
      .load_i     (1'b0),
      .load_val_i ('0),
      .q_o        (tx_cnt_o),
      .step_o     (tx_step),
      .ovf_o      (tx_ovf)
   );

   can_fc_errcnt #(.W(CNT_W), .BIG_STEP(ERR_STEP), .SATURATE(1'b1)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_big_i  (rx_err_i),
      .inc_one_i  (rx_err_one_i),
      .dec_i      (rx_ok_i),
      .freeze_i   (busoff),
      .clear_i    (clr),
      .load_i     (rx_load),
      .load_val_i (RELOAD_V),
      .q_o        (rx_cnt_o),
      .step_o     (rx_step),
      .ovf_o      (rx_ovf)
   );

   can_fc_recover #(.COUNT(RECOVER_COUNT)) u_rec (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (busoff),
      .pulse_i (recess_run_i),
      .done_o  (recov_done)
   );

   can_fc_ctrl #(.W(CNT_W), .LIMIT(PASSIVE_LIMIT)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_step_i     (tx_step),
      .rx_step_i     (rx_step),
      .tx_ovf_i      (tx_ovf & ~busoff),
      .recov_done_i  (recov_done),
      .state_o       (state),
      .rx_load_o     (rx_load),
      .clear_o       (clr),
      .irq_passive_o (irq_passive_o),
      .irq_busoff_o  (irq_busoff_o),
      .irq_active_o  (irq_active_o)
   );

   assign state_o = state;

   logic unused_ok;
   assign unused_ok = rx_ovf;

endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
   parameter int CNT_W         = 8,
   parameter int ERR_STEP      = 8,
   parameter int PASSIVE_LIMIT = 127
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_err_i,
   input logic             tx_ok_i,
   input logic             rx_err_i,
   input logic             rx_err_one_i,
   input logic             rx_ok_i,
   input logic             recess_run_i,
   input logic [CNT_W-1:0] tx_cnt_o,
   input logic [CNT_W-1:0] rx_cnt_o,
   input logic [1:0]       state_o,
   input logic             irq_passive_o,
   input logic             irq_busoff_o,
   input logic             irq_active_o
);

   localparam int MAX_V = (1 << CNT_W) - 1;

   assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'b10 && tx_err_i && int'(tx_cnt_o) + ERR_STEP <= MAX_V)
      |=> int'(tx_cnt_o) == int'($past(tx_cnt_o)) + ERR_STEP);

   assert_rx_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && rx_err_one_i && !rx_err_i)
      |=> int'(rx_cnt_o) == int'($past(rx_cnt_o)) + 1);

   assert_tx_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'b10 && tx_cnt_o == '0 && tx_ok_i && !tx_err_i)
      |=> tx_cnt_o == '0);

   assert_rx_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && rx_cnt_o == '0 && rx_ok_i && !rx_err_i && !rx_err_one_i)
      |=> rx_cnt_o == '0);

   assert_rx_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'b10 && int'(rx_cnt_o) == MAX_V && !rx_ok_i)
      |=> int'(rx_cnt_o) == MAX_V);

   assert_active_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00) |-> (int'(tx_cnt_o) <= PASSIVE_LIMIT && int'(rx_cnt_o) <= PASSIVE_LIMIT));

   assert_passive_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_passive_o |-> state_o == 2'b01);

   assert_busoff_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b01 && tx_err_i && int'(tx_cnt_o) + ERR_STEP > MAX_V)
      |=> (state_o == 2'b10 && $stable(tx_cnt_o) && irq_busoff_o));

   assert_busoff_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b10)
      |=> (state_o == 2'b10) ? ($stable(tx_cnt_o) && $stable(rx_cnt_o))
                             : (tx_cnt_o == '0 && rx_cnt_o == '0 && irq_active_o));

   assert_run_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && recess_run_i && !tx_err_i && !rx_err_i && !rx_err_one_i)
      |=> state_o == 2'b00);

   assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_passive_o, irq_busoff_o, irq_active_o}));

   assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'b11);

endmodule

bind can_fault_conf can_fault_conf_chk #(
   .CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .PASSIVE_LIMIT(PASSIVE_LIMIT)
) u_chk (.*);

// File: tb/sim_can_fault_conf.sv
`timescale 1ns/1ps
module sim_can_fault_conf;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_err, tx_ok, rx_err, rx_err1, rx_ok, run11;
   logic [7:0] tx_cnt, rx_cnt;
   logic [1:0] state;
   logic       irq_p, irq_b, irq_a;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   int m_tx = 0, m_rx = 0, m_st = 0, m_runs = 0;
   bit m_ip = 0, m_ib = 0, m_ia = 0;

   always #(PERIOD/2) clk = ~clk;

   can_fault_conf u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_err_i(tx_err), .tx_ok_i(tx_ok), .rx_err_i(rx_err),
      .rx_err_one_i(rx_err1), .rx_ok_i(rx_ok), .recess_run_i(run11),
      .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .state_o(state),
      .irq_passive_o(irq_p), .irq_busoff_o(irq_b), .irq_active_o(irq_a)
   );

   always @(posedge clk) begin
      int nt, nr, ns;
      bit ovf;
      if (!rst_n) begin
         m_tx = 0; m_rx = 0; m_st = 0; m_runs = 0;
         m_ip = 0; m_ib = 0; m_ia = 0;
      end else begin
         nt = m_tx; nr = m_rx; ns = m_st; ovf = 0;
         if (m_st == 2) begin
            if (run11) m_runs++;
            if (m_runs == 128) begin
               nt = 0; nr = 0; ns = 0; m_runs = 0;
            end
         end else begin
            if (tx_err) begin
               if (m_tx + 8 > 255) ovf = 1; else nt = m_tx + 8;
            end else if (tx_ok && m_tx > 0) nt = m_tx - 1;
            if (rx_err)       nr = (m_rx + 8 > 255) ? 255 : m_rx + 8;
            else if (rx_err1) nr = (m_rx + 1 > 255) ? 255 : m_rx + 1;
            else if (rx_ok && m_rx > 0) nr = m_rx - 1;
            if (ovf) begin
               ns = 2; m_runs = 0;
            end else if (m_st == 0 && (nt > 127 || nr > 127)) ns = 1;
            else if (m_st == 1 && nt <= 127 && nr <= 127) begin
               ns = 0; nr = 119;
            end
         end
         m_ip = (ns != m_st) && ns == 1;
         m_ib = (ns != m_st) && ns == 2;
         m_ia = (ns != m_st) && ns == 0;
         m_tx = nt; m_rx = nr; m_st = ns;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(tx_cnt) == m_tx, "R2 R3 R4 R8 R9 tx counter", tx_cnt, m_tx);
         chk(int'(rx_cnt) == m_rx, "R2 R3 R4 R5 R7 rx counter", rx_cnt, m_rx);
         chk(int'(state) == m_st, "R6 R7 R8 R10 state", state, m_st);
         chk({irq_p, irq_b, irq_a} == {m_ip, m_ib, m_ia}, "R6 R7 R8 R10 irq",
             {irq_p, irq_b, irq_a}, {m_ip, m_ib, m_ia});
      end
   end

   task automatic drive(input bit te, input bit to, input bit re, input bit r1,
                        input bit ro, input bit rr);
      @(negedge clk);
      tx_err = te; tx_ok = to; rx_err = re; rx_err1 = r1; rx_ok = ro; run11 = rr;
   endtask

   task automatic pulse(input bit te, input bit to, input bit re, input bit r1,
                        input bit ro, input bit rr);
      drive(te, to, re, r1, ro, rr);
      drive(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tx_err = 0; tx_ok = 0; rx_err = 0; rx_err1 = 0; rx_ok = 0; run11 = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(tx_cnt == 0 && rx_cnt == 0, "R1 counters", {tx_cnt, rx_cnt}, 0);
      chk(state == 2'b00 && !irq_p && !irq_b && !irq_a, "R1 state", state, 0);
      // R3 floor at zero
      pulse(0, 1, 0, 0, 1, 0);
      chk(tx_cnt == 0 && rx_cnt == 0, "R3 floor", {tx_cnt, rx_cnt}, 0);
      // R2 both receive increments together give 8
      pulse(0, 0, 1, 1, 0, 0);
      chk(rx_cnt == 8, "R2 rx combined", rx_cnt, 8);
      pulse(0, 0, 0, 1, 0, 0);
      chk(rx_cnt == 9, "R2 rx one", rx_cnt, 9);
      // R4 error beats success
      pulse(1, 1, 0, 0, 0, 0);
      chk(tx_cnt == 8, "R4 tx err+ok", tx_cnt, 8);
      pulse(0, 0, 0, 0, 1, 0);
      chk(rx_cnt == 8, "R3 rx decrement", rx_cnt, 8);
      // R6 / R5 drive receive counter high
      for (int i = 0; i < 15; i++) pulse(0, 0, 1, 0, 0, 0);
      chk(rx_cnt == 128 && state == 2'b01, "R6 passive entry", state, 1);
      for (int i = 0; i < 20; i++) pulse(0, 0, 1, 0, 0, 0);
      chk(rx_cnt == 255, "R5 rx ceiling", rx_cnt, 255);
      // R7 decrement back to threshold
      for (int i = 0; i < 128; i++) pulse(0, 0, 0, 0, 1, 0);
      chk(state == 2'b00 && rx_cnt == 119, "R7 reload on return", rx_cnt, 119);
      // R8 bus off from transmit overflow
      for (int i = 0; i < 30; i++) pulse(1, 0, 0, 0, 0, 0);
      chk(tx_cnt == 248 && state == 2'b01, "R8 tx at 248", tx_cnt, 248);
      drive(1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      chk(state == 2'b10 && tx_cnt == 248 && irq_b, "R8 bus off entry", state, 2);
      // R9 events ignored in bus off
      pulse(1, 1, 1, 1, 1, 0);
      chk(tx_cnt == 248 && rx_cnt == 119, "R9 frozen", tx_cnt, 248);
      // R10 recovery after 128 runs
      for (int i = 0; i < 127; i++) pulse(0, 0, 0, 0, 0, 1);
      chk(state == 2'b10, "R10 still bus off at 127", state, 2);
      drive(0, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0);
      chk(state == 2'b00 && tx_cnt == 0 && rx_cnt == 0 && irq_a, "R10 recovered", state, 0);
      // random traffic in phases
      for (int ph = 0; ph < 8; ph++) begin
         int pe = (ph % 2) ? 45 : 12;
         for (int c = 0; c < 900; c++) begin
            drive($urandom_range(0, 99) < pe, $urandom_range(0, 99) < 30,
                  $urandom_range(0, 99) < pe, $urandom_range(0, 99) < 10,
                  $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 60);
         end
      end
      drive(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule